// File: doc/BRIEF.md
# Serial DAC Daisy-Chain Write Controller

This block is a host-side sequencer that loads a whole daisy chain of identical 12-bit serial-input converters in a single frame. Every device in the chain sees the same serial clock and the same active-low select/load line. Data enters the device nearest the controller and ripples through each device into the next one. The controller accepts one frame worth of codes, one code per device, through a valid/ready handshake. It then drives the select line low and shifts out 12 x N bits, most significant bit first, starting with the device farthest from the controller. When the frame is complete it raises the select line, so every converter output updates at the same moment.

All serial timing comes from the system clock through per-phase cycle counts. These are the select-to-clock lead, clock high, clock low (which also covers the data setup), the last-clock-to-select-rise lag and the minimum select-high gap. Each count is rounded up from the interface minimums at the configured system frequency. The defaults suit a 250 MHz system clock. A readback register can be enabled. It samples the chain return line just before each serial clock rise, so after a frame it holds the codes that the chain contained before that frame.

The handshake applies back-pressure while a frame is running. `in_ready` stays low from the cycle a request is accepted until the select line has been high for its minimum gap. While `in_ready` is low, `in_valid` and `in_codes` are ignored. A request that is held waiting is taken on the first cycle in which `in_ready` is high.

Top module: `dac_chain_writer`

## Requirements
- R1: During reset and on the first cycle after it, `cs_n` is 1 and `sclk`, `done` and `in_ready` are 0. `in_ready` becomes 1 once `cs_n` has been high for `CSH_CYC` cycles after reset.
- R2: A request is accepted on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when the controller is idle. It returns to 1 exactly `CSH_CYC` cycles after the `done` cycle. A request presented while `in_ready` is 0 has no effect on the frame in progress and starts no new frame.
- R3: A frame has exactly 12 x N_DEV rising edges of `sclk`. Device k (k = 0 nearest the controller) receives `in_codes[12k+11:12k]`. The bit sent first is `in_codes` bit 12N-1 and the bit sent last is bit 0. After the frame, device k holds exactly its own code.
- R4: `cs_n` falls on the cycle after acceptance while `sclk` is low. The first `sclk` rise comes at least `LEAD_CYC` cycles after that.
- R5: Every `sclk` high phase lasts at least `HIGH_CYC` cycles. Every low phase between rises lasts at least `LOW_CYC` cycles. `sdata` changes only while `sclk` is low.
- R6: `cs_n` rises while `sclk` is low, at least `LAG_CYC` cycles after the last `sclk` fall. `cs_n` then stays high for at least `CSH_CYC` cycles.
- R7: `sclk` never rises while `cs_n` is high, and `cs_n` never falls while `sclk` is high.
- R8: `done` is a one-cycle pulse that is high in the same cycle in which `cs_n` first reads 1 at the end of a frame.
- R9: When `RB_EN` is 1, `rb_data` in the `done` cycle equals the frame the chain held before this frame, in the same bit layout as `in_codes`. The chain starts out cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame request valid |
| in_ready | output | 1 | Controller idle, ready to accept a request |
| in_codes | input | 12*N_DEV | One code per device; device k at bits 12k+11..12k |
| sclk | output | 1 | Serial clock to the chain, idles low |
| sdata | output | 1 | Serial data to the nearest device |
| cs_n | output | 1 | Shared active-low select/load, idles high |
| sdi | input | 1 | Return data from the last device of the chain |
| done | output | 1 | One-cycle pulse at the load edge |
| rb_data | output | 12*N_DEV | Captured chain contents of the previous frame |

## Verification
Each result has a fixed cycle in which it is due. `cs_n` is low one cycle after the accepting edge, and `done` follows exactly LEAD + 36·HIGH + 35·LOW + LAG cycles later. `in_ready` is 0 `CSH_CYC-1` cycles after `done` and is 1 one cycle after that. The bench samples on falling edges, checks `done` and `in_ready` in those exact cycles, and reads the converter model and `rb_data` in the `done` cycle. Phase lengths are measured by a monitor that samples 1 ns after each rising edge. Requests made while the controller is busy are shown to be ignored by checking the outputs that were latched and by confirming that no extra select fall occurs.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } dcw_state_e;
endpackage

// File: rtl/dcw_timer.sv
module dcw_timer #(
  parameter int W      = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= W'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dcw_shift.sv
module dcw_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dcw_pkg::*;
#(
  parameter int N_DEV    = 3,
  parameter int CODE_W   = 12,
  parameter int LEAD_CYC = 10,
  parameter int HIGH_CYC = 10,
  parameter int LOW_CYC  = 30,
  parameter int LAG_CYC  = 10,
  parameter int CSH_CYC  = 13,
  parameter bit RB_EN    = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_DEV*CODE_W-1:0]   in_codes,
  output logic                      sclk,
  output logic                      sdata,
  output logic                      cs_n,
  input  logic                      sdi,
  output logic                      done,
  output logic [N_DEV*CODE_W-1:0]   rb_data
);
  localparam int FRAME_W = N_DEV * CODE_W;
  localparam int MAX_A   = (LEAD_CYC > HIGH_CYC) ? LEAD_CYC : HIGH_CYC;
  localparam int MAX_B   = (LOW_CYC > LAG_CYC) ? LOW_CYC : LAG_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > CSH_CYC) ? MAX_C : CSH_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  dcw_state_e         state_q, state_d;
  logic [BIT_W-1:0]   bits_q, bits_d;
  logic               done_q, done_d;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               tx_load, tx_shift, rx_shift;
  logic [FRAME_W-1:0] tx_q;

  dcw_timer #(.W(TMR_W), .RST_VAL(CSH_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  dcw_shift #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_val(in_codes),
    .shift(tx_shift), .sin(1'b0), .q(tx_q)
  );

  generate
    if (RB_EN) begin : g_rb
      dcw_shift #(.W(FRAME_W)) u_rx (
        .clk(clk), .rst(rst), .load(1'b0), .load_val('0),
        .shift(rx_shift), .sin(sdi), .q(rb_data)
      );
    end else begin : g_no_rb
      assign rb_data = '0;
    end
  endgenerate

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) begin
        state_d  = ST_LEAD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(LEAD_CYC - 1);
        tx_load  = 1'b1;
        bits_d   = BIT_W'(FRAME_W);
      end
      ST_LEAD, ST_LOW: if (tmr_zero) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HIGH_CYC - 1);
        rx_shift = 1'b1;
      end
      ST_HIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bits_q == BIT_W'(1)) begin
          state_d = ST_TAIL;
          tmr_val = TMR_W'(LAG_CYC - 1);
        end else begin
          state_d  = ST_LOW;
          tmr_val  = TMR_W'(LOW_CYC - 1);
          tx_shift = 1'b1;
          bits_d   = bits_q - 1'b1;
        end
      end
      ST_TAIL: if (tmr_zero) begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CSH_CYC - 1);
        done_d   = 1'b1;
      end
      ST_GAP: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_GAP;
      bits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      done_q  <= done_d;
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign sclk     = (state_q == ST_HIGH);
  assign cs_n     = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign sdata    = tx_q[FRAME_W-1];
  assign done     = done_q;
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int LEAD_CYC = 10,
  parameter int HIGH_CYC = 10,
  parameter int LOW_CYC  = 30,
  parameter int LAG_CYC  = 10,
  parameter int CSH_CYC  = 13
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic sdata,
  input logic cs_n,
  input logic done,
  input logic in_ready
);
  localparam int MIN_LO = (LOW_CYC < LEAD_CYC) ? LOW_CYC : LEAD_CYC;

  logic [15:0] hi_run, lo_run, gap_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run  <= '0;
      lo_run  <= '0;
      gap_run <= '0;
    end else begin
      hi_run  <= !sclk ? '0 : ((hi_run  == '1) ? hi_run  : hi_run  + 1'b1);
      lo_run  <= sclk  ? '0 : ((lo_run  == '1) ? lo_run  : lo_run  + 1'b1);
      gap_run <= !cs_n ? '0 : ((gap_run == '1) ? gap_run : gap_run + 1'b1);
    end
  end

  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_run >= 16'(HIGH_CYC)); // R5
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> lo_run >= 16'(MIN_LO)); // R5
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R5
  AST_NO_CLK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n); // R7
  AST_SELECT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sclk); // R7
  AST_LOAD_LAG: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (!sclk && lo_run >= 16'(LAG_CYC))); // R6
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> gap_run >= 16'(CSH_CYC)); // R6
  AST_DONE_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (cs_n && !sclk)); // R2
endmodule

bind dac_chain_writer dcw_checker #(
  .LEAD_CYC(LEAD_CYC), .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC),
  .LAG_CYC(LAG_CYC), .CSH_CYC(CSH_CYC)
) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
  .done(done), .in_ready(in_ready)
);

// File: tb/tb_dac_chain_writer.sv
module tb_dac_chain_writer;
  localparam int N   = 3;
  localparam int CW  = 12;
  localparam int FW  = N * CW;
  localparam int LEAD = 10, HIGH = 10, LOW = 30, LAG = 10, CSH = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [FW-1:0] in_codes = '0;
  logic in_ready, sclk, sdata, cs_n, done, sdi;
  logic [FW-1:0] rb_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dac_chain_writer #(
    .N_DEV(N), .CODE_W(CW), .LEAD_CYC(LEAD), .HIGH_CYC(HIGH),
    .LOW_CYC(LOW), .LAG_CYC(LAG), .CSH_CYC(CSH), .RB_EN(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_codes(in_codes), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
    .sdi(sdi), .done(done), .rb_data(rb_data)
  );

  // Chain model: device 0 nearest the controller
  logic [CW-1:0] chain [N];
  logic [CW-1:0] held  [N];
  initial for (int k = 0; k < N; k++) begin chain[k] = '0; held[k] = '0; end
  assign sdi = chain[N-1][CW-1];

  always @(posedge sclk) begin
    chain[0] <= {chain[0][CW-2:0], sdata};
    for (int k = 1; k < N; k++) chain[k] <= {chain[k][CW-2:0], chain[k-1][CW-1]};
  end
  always @(posedge cs_n) for (int k = 0; k < N; k++) held[k] <= chain[k];

  // Phase monitor, sampled 1 ns after each rising edge
  int hi_run = 0, lo_run = 0, gap_run = 0;
  int rises = 0, cs_falls = 0;
  int min_hi, min_lo, lead, tail, last_gap;
  logic p_sclk = 1'b0, p_cs = 1'b1;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (p_sclk && !sclk && hi_run < min_hi) min_hi = hi_run;
      if (!p_sclk && sclk) begin
        if (rises == 0) lead = lo_run;
        else if (lo_run < min_lo) min_lo = lo_run;
        rises++;
      end
      if (p_cs && !cs_n) begin cs_falls++; rises = 0; last_gap = gap_run; end
      if (!p_cs && cs_n) tail = lo_run;
      hi_run  = sclk ? hi_run + 1 : 0;
      lo_run  = (!sclk && !cs_n) ? lo_run + 1 : 0;
      gap_run = cs_n ? gap_run + 1 : 0;
    end
    p_sclk = sclk;
    p_cs   = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [FW-1:0] prev = '0;

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 idle lines in reset", {cs_n, sclk}, 2'b10);
    chk(done === 1'b0 && in_ready === 1'b0, "R1 done/ready in reset", {done, in_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b0 && cs_n === 1'b1, "R1 ready low after reset", in_ready, 0);
    repeat (CSH + 1) @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready after gap", in_ready, 1);
  endtask

  task automatic run_frame(input logic [FW-1:0] codes, input bit poke);
    int wait_c = 0;
    while (!in_ready) @(negedge clk);
    min_hi = 1 << 30; min_lo = 1 << 30;
    in_valid = 1'b1; in_codes = codes;
    @(negedge clk);
    in_valid = 1'b0; in_codes = ~codes;
    chk(cs_n === 1'b0 && sclk === 1'b0, "R4 select falls with clock low", {cs_n, sclk}, 0);
    while (!done && wait_c < 5000) begin
      if (poke && wait_c > 100 && wait_c < 140) begin
        in_valid = 1'b1; in_codes = {FW{1'b1}} ^ codes;  // R2 ignored while busy
      end else in_valid = 1'b0;
      @(negedge clk);
      wait_c++;
    end
    in_valid = 1'b0;
    chk(done === 1'b1 && cs_n === 1'b1, "R8 done with select rise", {done, cs_n}, 2'b11);
    chk(rises == FW, "R3 clock rise count", rises, FW);
    for (int k = 0; k < N; k++)
      chk(held[k] == codes[k*CW +: CW], "R3 device code", held[k], codes[k*CW +: CW]);
    chk(rb_data == prev, "R9 readback of previous frame", rb_data, prev);
    chk(min_hi >= HIGH && min_lo >= LOW, "R5 phase widths", min_hi, HIGH);
    chk(lead >= LEAD, "R4 lead to first rise", lead, LEAD);
    chk(tail >= LAG, "R6 lag to select rise", tail, LAG);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (CSH - 2) @(negedge clk);
    chk(in_ready === 1'b0, "R2 ready held low in gap", in_ready, 0);
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 ready after gap", in_ready, 1);
    prev = codes;
  endtask

  task automatic t_ignore();
    int f0;
    run_frame({12'h0F0, 12'h00F, 12'hF00}, 1'b1);
    f0 = cs_falls;
    repeat (3 * CSH) @(negedge clk);
    chk(cs_falls == f0 && cs_n === 1'b1, "R2 busy request started nothing", cs_falls, f0);
  endtask

  task automatic t_back_to_back();
    run_frame({12'h5A5, 12'hABC, 12'h123}, 1'b0);
    run_frame({12'h001, 12'h800, 12'h7FE}, 1'b0);
    chk(last_gap >= CSH, "R6 select high gap", last_gap, CSH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    run_frame({12'hFFF, 12'hFFF, 12'hFFF}, 1'b0);   // all ones
    run_frame({12'h000, 12'h000, 12'h000}, 1'b0);   // all zeros
    run_frame({12'hAAA, 12'h555, 12'hAAA}, 1'b0);   // alternating
    t_back_to_back();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule